// File: doc/BRIEF.md
# Microcoded Memory-Cycle Pattern Sequencer

This block generates the pin-level timing of external memory cycles from a small microcode store rather than from a fixed state machine. A pattern RAM of 64 words, 32 bits each, holds one word per bus clock. The upper half of each word is driven straight onto sixteen chip-select and general-purpose strobe pins. The lower half carries control flags: end of pattern, transfer acknowledge, a repeat count, a loop-region marker and a wait enable.

Software loads the RAM through a two-register write port, a mode register and a data register. With the mode's operation field set to "load", every access request copies the data register into the RAM and advances the load pointer. With the field set to "normal", a request picks an entry word by access type. The sequencer then walks the pattern, applying repeats, one loop region with a programmable pass count, stalls on a synchronized external wait input, and a rerun of the whole pattern when an address-retry indication is seen.

Top module: `cycle_pattern_seq`

## Requirements
- R1: After reset and whenever the block is idle, `busy` is 0, `taOut` is 0 and `pinOut` equals the `IDLE_PINS` parameter (default 16'hFFFF).
- R2: The mode register (`regSel`=0) holds the operation in bits 1:0, the read pass count in bits 7:4, the write pass count in bits 11:8 and a load start address in bits 21:16. Writing it sets the load pointer to the start address. With operation 2'b01, a request accepted while idle writes the data register (`regSel`=1) to the RAM at the pointer, increments the pointer and does not raise `busy`.
- R3: With an operation other than 2'b01, an idle request starts a pattern at an entry word set by `reqType`: 0 (single read) at 0x00, 1 (single write) at 0x18, 2 (burst read) at 0x08, 3 (burst write) at 0x20. Word bits 31:16 appear on `pinOut` in the cycle after the edge that executes the word, and the entry word executes at the edge after acceptance.
- R4: A word with bit 2 set drives `taOut` high in its output cycle.
- R5: The repeat field in word bits 9:8 holds a word for that many extra cycles; a value of 3 gives 4 cycles.
- R6: Bit 7 marks a loop region: the first marked word opens it and the next marked word closes it. After the closing word, execution returns to the opening word for the configured number of extra passes (the read count for types 0 and 2, the write count for types 1 and 3). With repeats, the loop takes effect only on a word's final repetition.
- R7: Bit 0 marks the last word. `busy` rises at the acceptance edge and stays high through the output cycle of the last word. At the following edge the pins return to `IDLE_PINS`.
- R8: `waitIn` passes through a two-flop synchronizer. When the previously executed word has bit 12 (wait enable) set and the synchronized wait is high, the current word is executed again and `taOut` is held low for that cycle. Back-to-back wait-enable words therefore stall for as long as the wait is held.
- R9: A single wait-enable word followed by a word without it gives a stall of at most one cycle, even while the wait stays high.
- R10: `retryIn` seen while a pattern runs holds `taOut` low for the rest of that pass. At the last word the pattern restarts from its entry word with the loop state reloaded, and `taOut` works normally again.
- R11: Requests that arrive while `busy` is high are ignored, including RAM-load requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the mode register, 1 the data register |
| regWrData | input | 32 | Register write value |
| reqValid | input | 1 | Access request, sampled while idle |
| reqType | input | 2 | Access type: 0 single read, 1 single write, 2 burst read, 3 burst write |
| retryIn | input | 1 | Address-retry indication |
| waitIn | input | 1 | Asynchronous external wait |
| pinOut | output | 16 | Registered chip-select and strobe pins |
| taOut | output | 1 | Registered data-valid / transfer-acknowledge |
| busy | output | 1 | High while a pattern is in progress |

## Verification
An accepted request shows `busy` one cycle after its acceptance edge while the pins are still idle. The entry word reaches the pins one cycle later, and each following cycle shows exactly one executed word. The pins return to idle one cycle after the last word, when `busy` also falls. The scoreboard holds one expected entry per cycle (busy, pins, acknowledge) and compares it 1 ns after each rising edge, from the edge after the request is driven. For wait tests, the input is dropped a known number of edges after acceptance and the two-edge synchronizer lag is counted into the expected number of stalled cycles. Retry pulses and ignored requests are driven at fixed negative edges inside the run.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;
  localparam int PIN_W    = 16;
  localparam int LAST_BIT = 0;
  localparam int TA_BIT   = 2;
  localparam int LOOP_BIT = 7;
  localparam int REP_LSB  = 8;
  localparam int WAEN_BIT = 12;
  localparam int PIN_LSB  = 16;

  localparam int ENTRY_SINGLE_RD = 0;
  localparam int ENTRY_BURST_RD  = 8;
  localparam int ENTRY_SINGLE_WR = 24;
  localparam int ENTRY_BURST_WR  = 32;

  localparam logic [1:0] OP_LOAD = 2'b01;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_RUN, SEQ_DRAIN} seq_state_e;

  typedef struct packed {
    logic emitWord;
    logic parkPins;
    logic taOn;
    logic ramWr;
  } seq_strobe_t;

  typedef struct packed {
    logic       last;
    logic       ta;
    logic       loopMark;
    logic [1:0] rep;
    logic       waitEn;
  } word_ctl_t;
endpackage

// File: rtl/cps_datapath.sv
`timescale 1ns/1ps
module cps_datapath import cps_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int LOOP_W = 4,
  parameter logic [PIN_W-1:0] IDLE_PINS = 16'hFFFF,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [31:0]       regWrData,
  input  logic              waitIn,
  input  seq_strobe_t       strb,
  input  logic [ADDR_W-1:0] pc,
  output word_ctl_t         ctl,
  output logic              waitSync,
  output logic              modeProg,
  output logic [LOOP_W-1:0] rdLoop,
  output logic [LOOP_W-1:0] wrLoop,
  output logic [PIN_W-1:0]  pinOut,
  output logic              taOut
);
  logic [31:0]       patRam [DEPTH];
  logic [31:0]       curWord;
  logic [31:0]       dataReg;
  logic [ADDR_W-1:0] loadPtr;
  logic [1:0]        opReg;
  logic              waitMeta;
  logic              unusedWordBits;

  assign curWord = patRam[pc];
  assign ctl.last     = curWord[LAST_BIT];
  assign ctl.ta       = curWord[TA_BIT];
  assign ctl.loopMark = curWord[LOOP_BIT];
  assign ctl.rep      = curWord[REP_LSB +: 2];
  assign ctl.waitEn   = curWord[WAEN_BIT];
  assign unusedWordBits = ^{curWord[15:13], curWord[11:10], curWord[6:3], curWord[1]};
  assign modeProg = (opReg == OP_LOAD);

  // pattern store: written only through the load strobe
  always_ff @(posedge clk) begin
    if (strb.ramWr) patRam[loadPtr] <= dataReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= '0;
      rdLoop  <= '0;
      wrLoop  <= '0;
      dataReg <= '0;
      loadPtr <= '0;
    end else begin
      if (regWrEn && !regSel) begin
        opReg   <= regWrData[1:0];
        rdLoop  <= regWrData[4 +: LOOP_W];
        wrLoop  <= regWrData[8 +: LOOP_W];
        loadPtr <= regWrData[16 +: ADDR_W];
      end else if (strb.ramWr) begin
        loadPtr <= loadPtr + 1'b1;
      end
      if (regWrEn && regSel) dataReg <= regWrData;
    end
  end

  // two-stage synchronizer for the external wait
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitMeta <= 1'b0;
      waitSync <= 1'b0;
    end else begin
      waitMeta <= waitIn;
      waitSync <= waitMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinOut <= IDLE_PINS;
      taOut  <= 1'b0;
    end else if (strb.emitWord) begin
      pinOut <= curWord[PIN_LSB +: PIN_W];
      taOut  <= strb.taOn;
    end else if (strb.parkPins) begin
      pinOut <= IDLE_PINS;
      taOut  <= 1'b0;
    end
  end
endmodule

// File: rtl/cps_ctrl.sv
`timescale 1ns/1ps
module cps_ctrl import cps_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int LOOP_W = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic              retryIn,
  input  word_ctl_t         ctl,
  input  logic              waitSync,
  input  logic              modeProg,
  input  logic [LOOP_W-1:0] rdLoop,
  input  logic [LOOP_W-1:0] wrLoop,
  output logic [ADDR_W-1:0] pc,
  output seq_strobe_t       strb,
  output logic              busy
);
  seq_state_e        state;
  logic [1:0]        repCnt;
  logic              inLoop;
  logic              retryPend;
  logic              prevWaen;
  logic [ADDR_W-1:0] loopStart;
  logic [ADDR_W-1:0] entryPc;
  logic [ADDR_W-1:0] nextPc;
  logic [LOOP_W-1:0] loopLeft;
  logic [LOOP_W-1:0] loopInit;
  logic              stall;
  logic              retryNow;

  function automatic logic [ADDR_W-1:0] entryFor(input logic [1:0] kind);
    case (kind)
      2'd0:    return ADDR_W'(ENTRY_SINGLE_RD);
      2'd1:    return ADDR_W'(ENTRY_SINGLE_WR);
      2'd2:    return ADDR_W'(ENTRY_BURST_RD);
      default: return ADDR_W'(ENTRY_BURST_WR);
    endcase
  endfunction

  assign stall    = prevWaen && waitSync;
  assign retryNow = retryPend || retryIn;
  assign nextPc   = pc + 1'b1;
  assign busy     = (state != SEQ_IDLE);

  always_comb begin
    strb.emitWord = (state == SEQ_RUN);
    strb.parkPins = (state == SEQ_DRAIN);
    strb.taOn     = ctl.ta && !retryNow && !stall;
    strb.ramWr    = (state == SEQ_IDLE) && reqValid && modeProg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      pc        <= '0;
      entryPc   <= '0;
      repCnt    <= '0;
      inLoop    <= 1'b0;
      loopStart <= '0;
      loopLeft  <= '0;
      loopInit  <= '0;
      retryPend <= 1'b0;
      prevWaen  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (reqValid && !modeProg) begin
            state     <= SEQ_RUN;
            pc        <= entryFor(reqType);
            entryPc   <= entryFor(reqType);
            loopInit  <= reqType[0] ? wrLoop : rdLoop;
            loopLeft  <= reqType[0] ? wrLoop : rdLoop;
            inLoop    <= 1'b0;
            repCnt    <= '0;
            retryPend <= 1'b0;
            prevWaen  <= 1'b0;
          end
        end
        SEQ_RUN: begin
          retryPend <= retryNow;
          prevWaen  <= ctl.waitEn;
          if (!stall) begin
            if (repCnt != ctl.rep) begin
              repCnt <= repCnt + 2'd1;
            end else begin
              repCnt <= '0;
              if (ctl.last) begin
                if (retryNow) begin
                  pc        <= entryPc;
                  loopLeft  <= loopInit;
                  inLoop    <= 1'b0;
                  retryPend <= 1'b0;
                  prevWaen  <= 1'b0;
                end else begin
                  state <= SEQ_DRAIN;
                end
              end else if (ctl.loopMark && inLoop && (pc != loopStart)) begin
                if (loopLeft != '0) begin
                  loopLeft <= loopLeft - 1'b1;
                  pc       <= loopStart;
                end else begin
                  inLoop <= 1'b0;
                  pc     <= nextPc;
                end
              end else if (ctl.loopMark && !inLoop) begin
                inLoop    <= 1'b1;
                loopStart <= pc;
                pc        <= nextPc;
              end else begin
                pc <= nextPc;
              end
            end
          end
        end
        SEQ_DRAIN: state <= SEQ_IDLE;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cycle_pattern_seq.sv
`timescale 1ns/1ps
module cycle_pattern_seq import cps_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int LOOP_W = 4,
  parameter logic [PIN_W-1:0] IDLE_PINS = 16'hFFFF,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [31:0]      regWrData,
  input  logic             reqValid,
  input  logic [1:0]       reqType,
  input  logic             retryIn,
  input  logic             waitIn,
  output logic [PIN_W-1:0] pinOut,
  output logic             taOut,
  output logic             busy
);
  seq_strobe_t       strb;
  word_ctl_t         ctl;
  logic [ADDR_W-1:0] pc;
  logic              waitSync;
  logic              modeProg;
  logic [LOOP_W-1:0] rdLoop;
  logic [LOOP_W-1:0] wrLoop;

  cps_ctrl #(.DEPTH(DEPTH), .LOOP_W(LOOP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .retryIn(retryIn), .ctl(ctl), .waitSync(waitSync), .modeProg(modeProg),
    .rdLoop(rdLoop), .wrLoop(wrLoop), .pc(pc), .strb(strb), .busy(busy)
  );

  cps_datapath #(.DEPTH(DEPTH), .LOOP_W(LOOP_W), .IDLE_PINS(IDLE_PINS)) u_datapath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .waitIn(waitIn), .strb(strb), .pc(pc), .ctl(ctl),
    .waitSync(waitSync), .modeProg(modeProg), .rdLoop(rdLoop), .wrLoop(wrLoop),
    .pinOut(pinOut), .taOut(taOut)
  );
endmodule

// File: rtl/cps_checker.sv
`timescale 1ns/1ps
module cps_checker #(
  parameter logic [15:0] IDLE_PINS = 16'hFFFF
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        retryIn,
  input logic        modeProg,
  input logic        busy,
  input logic        taOut,
  input logic [15:0] pinOut
);
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (pinOut == IDLE_PINS) && !taOut);

  assert_busy_needs_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  assert_ta_inside_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    taOut |-> busy);

  assert_retry_masks_ta_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && retryIn) |=> !taOut);

  assert_load_stays_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && modeProg) |=> !busy);
endmodule

bind cycle_pattern_seq cps_checker #(.IDLE_PINS(IDLE_PINS)) u_cps_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .retryIn(retryIn),
  .modeProg(modeProg), .busy(busy), .taOut(taOut), .pinOut(pinOut)
);

// File: tb/cycle_pattern_seq_bench.sv
`timescale 1ns/1ps
module cycle_pattern_seq_bench;
  localparam int CLK_NS = 4;
  localparam logic [15:0] IDLE = 16'hFFFF;
  localparam int S    = 256;
  localparam int LAST = 32'h1;
  localparam int TA   = 32'h4;
  localparam int LOOP = 32'h80;
  localparam int REP3 = 32'h300;
  localparam int WAEN = 32'h1000;

  typedef struct {
    logic        busy;
    logic [15:0] pins;
    logic        ta;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN, regWrEn, regSel, reqValid, retryIn, waitIn;
  logic [31:0] regWrData;
  logic [1:0]  reqType;
  logic [15:0] pinOut;
  logic        taOut, busy;

  int checks = 0;
  int fails = 0;
  int rdL = 1;
  int wrL = 2;
  exp_t q[$];
  int tr[$];
  logic [31:0] ld[$];
  logic [31:0] img [64];

  always #(CLK_NS/2) clk = ~clk;

  cycle_pattern_seq u_cycle_pattern_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .reqValid(reqValid), .reqType(reqType),
    .retryIn(retryIn), .waitIn(waitIn), .pinOut(pinOut), .taOut(taOut),
    .busy(busy)
  );

  function automatic logic [31:0] mkw(input int pc, input int fl);
    return {16'hA000 | 16'(pc), 16'(fl)};
  endfunction

  function automatic logic [31:0] modeWord(input int op, input int start);
    return 32'(op) | (32'(rdL) << 4) | (32'(wrL) << 8) | (32'(start) << 16);
  endfunction

  function automatic exp_t mkExp(input logic b, input logic [15:0] p, input logic t,
                                 input string tag);
    exp_t e;
    e.busy = b; e.pins = p; e.ta = t; e.tag = tag;
    return e;
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // R2: load words from ld[] starting at a given address
  task automatic progAt(input int start);
    regWrite(1'b0, modeWord(1, start));
    foreach (ld[i]) begin
      regWrite(1'b1, ld[i]);
      @(negedge clk); reqValid = 1'b1; reqType = 2'd0;
      @(negedge clk); reqValid = 1'b0;
      img[start + i] = ld[i];
    end
  endtask

  task automatic runSeq(input logic [1:0] kind, input string tag);
    @(negedge clk);
    reqType = kind; reqValid = 1'b1;
    q.push_back(mkExp(1'b1, IDLE, 1'b0, tag));
    foreach (tr[i]) begin
      logic [31:0] w;
      w = img[tr[i] & 63];
      q.push_back(mkExp(1'b1, w[31:16], w[2] && ((tr[i] & S) == 0), tag));
    end
    q.push_back(mkExp(1'b0, IDLE, 1'b0, tag));
    @(negedge clk);
    reqValid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic atNeg(input int k);
    @(negedge clk);
    repeat (k + 1) @(negedge clk);
  endtask

  task automatic checkIdle(input string tag);
    checks++;
    if (busy !== 1'b0 || pinOut !== IDLE || taOut !== 1'b0) begin
      fails++;
      $display("FAIL %s: busy/pins/ta = %0b/%h/%0b expected 0/%h/0", tag, busy, pinOut,
               taOut, IDLE);
    end
  endtask

  // scoreboard monitor: one expected entry per cycle, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (busy !== e.busy || pinOut !== e.pins || taOut !== e.ta) begin
          fails++;
          $display("FAIL %s: busy/pins/ta = %0b/%h/%0b expected %0b/%h/%0b", e.tag,
                   busy, pinOut, taOut, e.busy, e.pins, e.ta);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: run still active, expected completion");
    report();
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regSel = 1'b0; regWrData = '0;
    reqValid = 1'b0; reqType = '0; retryIn = 1'b0; waitIn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 reset");

    ld = '{mkw(0, 0), mkw(1, REP3), mkw(2, LOOP), mkw(3, TA), mkw(4, LOOP),
           mkw(5, LAST | TA)};
    progAt(0);
    ld = '{mkw(8, 0), mkw(9, TA), mkw(10, TA), mkw(11, TA), mkw(12, TA), mkw(13, LAST)};
    progAt(8);
    ld = '{mkw(24, 0), mkw(25, WAEN), mkw(26, WAEN | TA), mkw(27, LAST)};
    progAt(24);
    ld = '{mkw(32, LOOP), mkw(33, TA), mkw(34, LOOP | TA), mkw(35, LAST)};
    progAt(32);
    regWrite(1'b0, modeWord(0, 0));
    checkIdle("R1 R2 idle after loading");

    tr = '{8, 9, 10, 11, 12, 13};
    runSeq(2'd2, "R2 R3 R4 R7 burst read");

    tr = '{0, 1, 1, 1, 1, 2, 3, 4, 2, 3, 4, 5};
    runSeq(2'd0, "R3 R5 R6 single read");

    tr = '{32, 33, 34, 32, 33, 34, 32, 33, 34, 35};
    runSeq(2'd3, "R3 R6 burst write");

    tr = '{24, 25, 26, 27};
    runSeq(2'd1, "R3 R8 wait low");

    // R8: wait held, dropped after edge 4; two-edge sync lag gives 4 stalls
    waitIn = 1'b1;
    repeat (4) @(negedge clk);
    tr = '{24, 25, S | 26, S | 26, S | 26, S | 26, 26, 27};
    fork
      runSeq(2'd1, "R8 continuous stall");
      begin atNeg(4); waitIn = 1'b0; end
    join
    repeat (3) @(negedge clk);

    // R9: single wait-enable word gives one stall only
    ld = '{mkw(26, TA)};
    progAt(26);
    regWrite(1'b0, modeWord(0, 0));
    waitIn = 1'b1;
    repeat (4) @(negedge clk);
    tr = '{24, 25, S | 26, 26, 27};
    runSeq(2'd1, "R9 single wait enable");
    waitIn = 1'b0;
    repeat (4) @(negedge clk);

    // R10: retry pulse sampled at edge 2, first pass without acknowledge, then rerun
    tr = {};
    begin
      int base[$];
      base = '{0, 1, 1, 1, 1, 2, 3, 4, 2, 3, 4, 5};
      foreach (base[i]) tr.push_back(base[i] | S);
      foreach (base[i]) tr.push_back(base[i]);
    end
    fork
      runSeq(2'd0, "R10 retry rerun");
      begin atNeg(1); retryIn = 1'b1; @(negedge clk); retryIn = 1'b0; end
    join

    // R11: access request while busy ignored
    tr = '{8, 9, 10, 11, 12, 13};
    fork
      runSeq(2'd2, "R11 request while busy");
      begin
        atNeg(2);
        reqType = 2'd3; reqValid = 1'b1;
        q.push_back(mkExp(1'b0, IDLE, 1'b0, "R11 no second start"));
        @(negedge clk);
        reqValid = 1'b0;
      end
    join

    // R11: load request while busy must not alter word 0x08
    fork
      runSeq(2'd2, "R11 load while busy");
      begin
        regWrite(1'b0, modeWord(1, 8));
        regWrite(1'b1, 32'hFFFF_FFFF);
        @(negedge clk); reqValid = 1'b1; reqType = 2'd0;
        @(negedge clk); reqValid = 1'b0;
        regWrite(1'b0, modeWord(0, 0));
      end
    join
    runSeq(2'd2, "R11 pattern unchanged");
    checkIdle("R1 final idle");

    report();
    $finish;
  end
endmodule